// File: doc/BRIEF.md
# Phase-Absorbing Recentering Word FIFO

This block carries 16-bit words from an upstream word clock into a locally generated word clock of the same frequency. The two clocks may sit at any fixed phase relative to each other and may wander slowly. One word is written on every write-clock edge and one word is read on every read-clock edge; there is no handshake. Eight words of storage sit between the two sides. The read pointer is kept a fixed distance behind the write pointer, so a phase step or a slow drift is absorbed as a change in occupancy rather than as lost data.

The write pointer crosses into the read domain as Gray code through a two-flop synchronizer. The read side works out occupancy from the synchronized pointer. It raises a sticky error flag when the occupancy reaches either end of the storage. Realignment only moves the read pointer: it is placed four entries behind the synchronized write position. Four events cause a realignment: an explicit request, reset, a built-in power-up realignment a few read cycles after reset is released, and each rising edge of an asynchronous lock indication. The error flag can be wired straight back to the request input, so the block repairs itself. For a short window after each realignment the read output is held at zero, so stale or unwritten entries never reach downstream logic.

Top module: `phase_fifo`

## Requirements
- R1: With the clocks at a steady phase, every word presented on `wr_data` at a write edge later appears on `rd_data` exactly once, in write order, one word per read cycle.
- R2: While `rst` is high, and on the read cycle after it, `fifo_err` is 0 and `rd_data` is 0. Three read cycles after release the pointers realign on their own, and the word stream then resumes.
- R3: When `recenter_in` is high at a read-clock edge, the read pointer moves so that the synchronized occupancy equals 4 (half of eight) and `fifo_err` clears.
- R4: A rising edge of the asynchronous `lock_in` is synchronized in the read domain and causes the same realignment as R3 within four read cycles. A steady high level or a falling edge has no effect.
- R5: After any realignment, `rd_data` reads 0 on the realigning cycle and on the four read cycles after it. It then carries valid words.
- R6: `fifo_err` goes high when the synchronized occupancy reaches 0 (the reader has gained four words) or 8 (the writer has gained four words).
- R7: A drift of up to three words in either direction from the centered position leaves `fifo_err` low.
- R8: Once high, `fifo_err` stays high until the next realignment (request, lock edge or reset).
- R9: With `fifo_err` looped back to `recenter_in`, an error lasts one read cycle, the block realigns, and the word stream resumes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Upstream word clock; a word is stored on every rising edge |
| rd_clk | input | 1 | Local word clock; a word is read on every rising edge |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_data | input | 16 | Word to store |
| lock_in | input | 1 | Asynchronous lock indication; its rising edge realigns |
| recenter_in | input | 1 | Read-domain realign request; may be tied to `fifo_err` |
| rd_data | output | 16 | Word read, zero while blanked after a realignment |
| fifo_err | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench moves the read clock against the write clock. It inserts stretched read periods and doubled read edges, each worth one word of drift. It probes the exact error thresholds: three words each way must leave the flag low, and four words must raise it. A design that counted occupancy with an off-by-one, or recentered to the live synchronizer output instead of the value about to land in it, would flag at three words or stay silent at four. After every realignment the bench counts the zero words exactly and then checks that the values resume with no gap or repeat. A wrong blanking length, or a read pointer left one slot off, shows up there as a short or long zero run or as a skipped or repeated value. The lock input gets a steady-high phase and a falling edge while an error is pending, which catches a level-sensitive or both-edge detector. The loopback run catches an error flag that fails to clear from its own request.

// File: rtl/phfifo_pkg.sv
package phfifo_pkg;

    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_ADDR_W   = 3;
    localparam int unsigned DEF_SYNC_LEN = 2;

    // Classification of the synchronized occupancy seen by the reader.
    typedef enum logic [1:0] {
        FILL_MID   = 2'd0,
        FILL_DRY   = 2'd1,
        FILL_FLOOD = 2'd2
    } fill_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Occupancy values at or above depth include wrapped (negative) distances.
    function automatic fill_e judge_fill(input logic [31:0] occ, input int unsigned depth);
        if (occ == 32'd0) begin
            return FILL_DRY;
        end else if (occ >= depth) begin
            return FILL_FLOOD;
        end
        return FILL_MID;
    endfunction

endpackage

// File: rtl/phfifo_sync.sv
module phfifo_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_early
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q       = chain[STAGES-1];
    assign q_early = chain[STAGES-2];
endmodule

// File: rtl/phfifo_wr.sv
module phfifo_wr
    import phfifo_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] wr_ptr_inc;

    assign wr_ptr_inc = wr_ptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            wr_gray <= '0;
        end else begin
            wr_ptr  <= wr_ptr_inc;
            wr_gray <= PTR_W'(to_gray(32'(wr_ptr_inc)));
        end
    end

    assign wr_addr = wr_ptr[ADDR_W-1:0];
endmodule

// File: rtl/phfifo_store.sv
module phfifo_store #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [WORD_W-1:0] slot;
        always_ff @(posedge wr_clk) begin
            if (wr_addr == ADDR_W'(i)) begin
                slot <= wr_word;
            end
        end
        assign cells[i] = slot;
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/phfifo_lock_edge.sv
module phfifo_lock_edge #(
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_async,
    output logic lock_rise
);
    logic lock_now;
    logic lock_old;

    // One stage beyond the synchronizer keeps the previous sample for edge detection.
    phfifo_sync #(.W(1), .STAGES(SYNC_LEN + 1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (lock_async),
        .q       (lock_old),
        .q_early (lock_now)
    );

    assign lock_rise = lock_now & ~lock_old;
endmodule

// File: rtl/phfifo_rd.sv
module phfifo_rd
    import phfifo_pkg::*;
#(
    parameter int unsigned WORD_W   = DEF_WORD_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              recenter_req,
    input  logic              lock_rise,
    input  logic [ADDR_W:0]   wsync_gray,
    input  logic [ADDR_W:0]   wsync_next,
    input  logic [WORD_W-1:0] mem_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              err,
    output logic [ADDR_W:0]   occ,
    output logic              realign
);
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned PTR_W   = ADDR_W + 1;
    localparam int unsigned CENTER  = DEPTH / 2;
    localparam int unsigned BOOT    = SYNC_LEN + 1;
    localparam int unsigned BLANK_W = $clog2(CENTER + 1);
    localparam int unsigned BOOT_W  = $clog2(BOOT + 1);

    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   wr_now;
    logic [PTR_W-1:0]   wr_next;
    logic [BLANK_W-1:0] blank_q;
    logic [BOOT_W-1:0]  boot_q;
    logic               boot_fire;
    logic               err_q;
    logic [WORD_W-1:0]  dout_q;
    fill_e              fill;

    assign wr_now    = PTR_W'(from_gray(32'(wsync_gray)));
    assign wr_next   = PTR_W'(from_gray(32'(wsync_next)));
    assign occ       = wr_now - rd_ptr;
    assign fill      = judge_fill(32'(occ), DEPTH);
    assign boot_fire = (boot_q == BOOT_W'(1));
    assign realign   = recenter_req | lock_rise | boot_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= PTR_W'(2 * DEPTH - CENTER);
            blank_q <= BLANK_W'(CENTER);
            boot_q  <= BOOT_W'(BOOT);
            err_q   <= 1'b0;
            dout_q  <= '0;
        end else begin
            if (boot_q != '0) begin
                boot_q <= boot_q - BOOT_W'(1);
            end
            if (realign) begin
                // Target the synchronizer value that becomes visible next cycle.
                rd_ptr  <= wr_next - PTR_W'(CENTER);
                blank_q <= BLANK_W'(CENTER);
                err_q   <= 1'b0;
                dout_q  <= '0;
            end else begin
                rd_ptr <= rd_ptr + PTR_W'(1);
                if (boot_q == '0 && fill != FILL_MID) begin
                    err_q <= 1'b1;
                end
                if (blank_q != '0) begin
                    blank_q <= blank_q - BLANK_W'(1);
                    dout_q  <= '0;
                end else begin
                    dout_q <= mem_word;
                end
            end
        end
    end

    assign rd_addr = rd_ptr[ADDR_W-1:0];
    assign rd_data = dout_q;
    assign err     = err_q;
endmodule

// File: rtl/phase_fifo.sv
module phase_fifo
    import phfifo_pkg::*;
#(
    parameter int unsigned WORD_W   = DEF_WORD_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lock_in,
    input  logic              recenter_in,
    output logic [WORD_W-1:0] rd_data,
    output logic              fifo_err
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [ADDR_W-1:0] wr_addr;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  wsync_gray;
    logic [PTR_W-1:0]  wsync_next;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] mem_word;
    logic              lock_rise;
    logic [PTR_W-1:0]  rd_occ;
    logic              realign;

    phfifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk     (wr_clk),
        .rst     (rst),
        .wr_addr (wr_addr),
        .wr_gray (wr_gray)
    );

    phfifo_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk  (wr_clk),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_addr (rd_addr),
        .rd_word (mem_word)
    );

    phfifo_sync #(.W(PTR_W), .STAGES(SYNC_LEN)) u_wsync (
        .clk     (rd_clk),
        .rst     (rst),
        .d       (wr_gray),
        .q       (wsync_gray),
        .q_early (wsync_next)
    );

    phfifo_lock_edge #(.SYNC_LEN(SYNC_LEN)) u_lock (
        .clk        (rd_clk),
        .rst        (rst),
        .lock_async (lock_in),
        .lock_rise  (lock_rise)
    );

    phfifo_rd #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SYNC_LEN(SYNC_LEN)) u_rd (
        .clk          (rd_clk),
        .rst          (rst),
        .recenter_req (recenter_in),
        .lock_rise    (lock_rise),
        .wsync_gray   (wsync_gray),
        .wsync_next   (wsync_next),
        .mem_word     (mem_word),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .err          (fifo_err),
        .occ          (rd_occ),
        .realign      (realign)
    );
endmodule

// File: rtl/phase_fifo_chk.sv
module phase_fifo_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst,
    input logic              recenter_in,
    input logic              lock_rise,
    input logic              realign,
    input logic              fifo_err,
    input logic [WORD_W-1:0] rd_data,
    input logic [ADDR_W:0]   rd_occ,
    input logic [ADDR_W:0]   wr_gray
);
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned CENTER = DEPTH / 2;

    AST_RESET_QUIET: assert property (@(posedge rd_clk)
        rst |=> (!fifo_err && rd_data == '0)); // R2

    AST_REQUEST_CENTERS: assert property (@(posedge rd_clk) disable iff (rst)
        recenter_in |=> (rd_occ == (ADDR_W+1)'(CENTER) && !fifo_err)); // R3

    AST_LOCK_CENTERS: assert property (@(posedge rd_clk) disable iff (rst)
        lock_rise |=> (rd_occ == (ADDR_W+1)'(CENTER) && !fifo_err)); // R4

    AST_BLANK_AFTER_ALIGN: assert property (@(posedge rd_clk) disable iff (rst)
        realign |=> (rd_data == '0)); // R5

    AST_ERR_CAUSE: assert property (@(posedge rd_clk) disable iff (rst)
        $rose(fifo_err) |-> ($past(rd_occ) == '0 || $past(rd_occ) >= (ADDR_W+1)'(DEPTH))); // R6

    AST_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (rst)
        (fifo_err && !realign) |=> fifo_err); // R8

    AST_GRAY_SINGLE_STEP: assert property (@(posedge wr_clk) disable iff (rst)
        !rst |=> ($countones(wr_gray ^ $past(wr_gray)) == 1)); // R1
endmodule

bind phase_fifo phase_fifo_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst         (rst),
    .recenter_in (recenter_in),
    .lock_rise   (lock_rise),
    .realign     (realign),
    .fifo_err    (fifo_err),
    .rd_data     (rd_data),
    .rd_occ      (rd_occ),
    .wr_gray     (wr_gray)
);

// File: tb/phase_fifo_test.sv
module phase_fifo_test;
    localparam int HALF_NS = 10;   // 50 MHz on both word clocks
    localparam int BLANK_RUN = 5;  // realign cycle plus four blanked reads

    // Drift vectors: {fast reader, drift units, expected error}
    localparam int NVEC = 7;
    localparam logic [5:0] DRIFT_TAB [NVEC] = '{
        {1'b0, 4'd2, 1'b0},
        {1'b0, 4'd3, 1'b0},
        {1'b0, 4'd4, 1'b1},
        {1'b1, 4'd2, 1'b0},
        {1'b1, 4'd3, 1'b0},
        {1'b1, 4'd4, 1'b1},
        {1'b0, 4'd6, 1'b1}
    };

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst = 1'b1;
    logic        lock = 1'b0;
    logic        rcn = 1'b0;
    logic        loop_en = 1'b0;
    logic [15:0] din = 16'h0100;
    logic [15:0] dout;
    logic        err;
    logic        rec_in;

    int total = 0;
    int bad = 0;
    int fast_units = 0;
    int slow_units = 0;
    int err_seen = 0;
    bit done = 1'b0;

    assign rec_in = loop_en ? err : rcn;

    phase_fifo uut (
        .wr_clk      (wclk),
        .rd_clk      (rclk),
        .rst         (rst),
        .wr_data     (din),
        .lock_in     (lock),
        .recenter_in (rec_in),
        .rd_data     (dout),
        .fifo_err    (err)
    );

    always #HALF_NS wclk = ~wclk;

    // Read clock lags by 7 ns; each unit shifts the reader by one word.
    initial begin
        #7;
        forever begin
            if (fast_units > 0) begin
                rclk = 1'b1; #5; rclk = 1'b0; #5;
                rclk = 1'b1; #5; rclk = 1'b0; #5;
                fast_units--;
            end else if (slow_units > 0) begin
                rclk = 1'b1; #20; rclk = 1'b0; #20;
                slow_units--;
            end else begin
                rclk = 1'b1; #10; rclk = 1'b0; #10;
            end
        end
    end

    always @(negedge wclk) din <= din + 16'd1;

    always @(negedge rclk) if (err) err_seen++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rcyc(input int n);
        repeat (n) @(negedge rclk);
    endtask

    task automatic verify_stream(input string tag);
        logic [15:0] prev;
        int steps_bad;
        prev = dout;
        steps_bad = (dout == 16'd0) ? 1 : 0;
        repeat (12) begin
            @(negedge rclk);
            if (dout != prev + 16'd1) steps_bad++;
            prev = dout;
        end
        check(steps_bad == 0, tag, steps_bad, 0);
    endtask

    task automatic realign_and_verify(input string tag);
        int zeros;
        @(negedge rclk) rcn = 1'b1;
        @(negedge rclk) rcn = 1'b0;
        zeros = 0;
        while (dout == 16'd0 && zeros < 20) begin
            zeros++;
            @(negedge rclk);
        end
        check(zeros == BLANK_RUN, "R5 blank run", zeros, BLANK_RUN);
        check(err == 1'b0, {tag, " err cleared"}, int'(err), 0);
        verify_stream({"R1 order after ", tag});
    endtask

    task automatic apply_drift(input bit fast, input int units);
        @(negedge rclk);
        if (fast) fast_units = units;
        else      slow_units = units;
        wait (fast_units == 0 && slow_units == 0);
        rcyc(8);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2: reset state, then automatic power-up realignment
        rcyc(6);
        check(err == 1'b0, "R2 err in reset", int'(err), 0);
        check(dout == 16'd0, "R2 data in reset", int'(dout), 0);
        @(negedge rclk) rst = 1'b0;
        rcyc(12);
        check(err == 1'b0, "R2 err after boot", int'(err), 0);
        verify_stream("R2 stream after boot");

        // R6/R7 thresholds, R3 recovery, R5 blanking, R1 order
        for (int i = 0; i < NVEC; i++) begin
            logic [5:0] v;
            v = DRIFT_TAB[i];
            apply_drift(v[5], int'(v[4:1]));
            check(err == v[0], v[0] ? "R6 threshold" : "R7 tolerance", int'(err), int'(v[0]));
            realign_and_verify("R3");
        end

        // R8: error holds with no realignment
        apply_drift(1'b0, 5);
        check(err == 1'b1, "R6 overflow", int'(err), 1);
        rcyc(20);
        check(err == 1'b1, "R8 sticky", int'(err), 1);

        // R4: lock rising edge realigns
        @(negedge rclk) lock = 1'b1;
        rcyc(6);
        check(err == 1'b0, "R4 lock rise clears", int'(err), 0);
        rcyc(6);
        verify_stream("R4 stream after lock");
        apply_drift(1'b0, 5);
        rcyc(10);
        check(err == 1'b1, "R4 steady lock no effect", int'(err), 1);
        @(negedge rclk) lock = 1'b0;
        rcyc(10);
        check(err == 1'b1, "R4 falling lock no effect", int'(err), 1);
        realign_and_verify("R3");

        // R9: error looped back to the request input
        @(negedge rclk) begin loop_en = 1'b1; err_seen = 0; end
        apply_drift(1'b0, 5);
        rcyc(20);
        check(err_seen == 1, "R9 single error cycle", err_seen, 1);
        check(err == 1'b0, "R9 self recovered", int'(err), 0);
        verify_stream("R9 stream");
        @(negedge rclk) loop_en = 1'b0;

        // R2: reset in the middle of an error
        apply_drift(1'b1, 5);
        check(err == 1'b1, "R6 underflow", int'(err), 1);
        @(negedge rclk) rst = 1'b1;
        rcyc(4);
        check(err == 1'b0 && dout == 16'd0, "R2 mid-run reset", int'(err), 0);
        @(negedge rclk) rst = 1'b0;
        rcyc(12);
        verify_stream("R2 stream after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule